// File: doc/BRIEF.md
# Interrupt Acceptance and Entry Sequencer

This block sits beside the control unit of a small microcontroller core. At each instruction boundary it decides whether a pending hardware interrupt may be taken. It also handles the software interrupt instruction whenever the decoder reports one. For every accepted interrupt it raises a take strobe and supplies the 16-bit entry address. It asks the stack logic to save the flag register, so entry works like a subroutine call with one extra word pushed. For hardware sources only, it also pulses an acknowledge to the peripherals and a request to clear the interrupt-enable flag.

Hardware acceptance has two guards. The first tracks writes to the two stack pointer registers. Nothing, including the non-maskable request, is taken until both pointers have been written as a pair. The second delays acceptance by one instruction whenever the decoder reports an instruction that writes the flag register or sets the extension flag. The non-maskable line is edge-captured, so a brief pulse waits until it can be served.

Top module: `irq_gate`

## Requirements
- R1: After reset all outputs are 0, and no hardware interrupt (non-maskable included) is accepted until both `sp1_wr` and `sp2_wr` have been seen, in the same cycle or in either order.
- R2: A write to only one stack pointer while the pair is valid blocks all hardware interrupts until the other pointer is written. Writing the same pointer again meanwhile keeps them blocked. Writing both in one cycle makes the pair valid.
- R3: A cycle with `flag_wr`=1 makes the next boundary after it (boundaries in that same cycle not counted) refuse every hardware interrupt. The boundary after that accepts normally.
- R4: `swi`=1 is accepted in that cycle regardless of `ien`, the pair state, deferral or `boundary`. Its vector is 0x0100 | `swi_addr`, with `ack`=0, `ien_clr`=0 and `push_f`=1.
- R5: A maskable request is accepted only when `irq`=1, `ien`=1 and `boundary`=1 with no guard blocking. Its vector is `irq_vec`.
- R6: The non-maskable request ignores `ien`, uses vector 0x0100, and is captured on a rising edge of `nmi`. The captured request stays pending until accepted, even after the line falls.
- R7: At most one interrupt is accepted per cycle. The order is software first, then non-maskable, then maskable.
- R8: A hardware acceptance drives `ack` and `ien_clr` high for exactly one cycle. Every acceptance drives `push_f` high with `take`.
- R9: All outputs are registered. They show the decision made at the clock edge where the inputs were sampled, and return to 0 in the next cycle unless another acceptance occurs. Hardware acceptance happens only with `boundary`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary | input | 1 | Instruction boundary, where hardware interrupts may be taken |
| irq | input | 1 | Maskable request level |
| irq_vec | input | 16 | Entry address for the maskable request |
| nmi | input | 1 | Non-maskable request, edge-captured |
| ien | input | 1 | Current interrupt-enable flag |
| sp1_wr | input | 1 | Write strobe of the first stack pointer |
| sp2_wr | input | 1 | Write strobe of the second stack pointer |
| flag_wr | input | 1 | Decoded instruction writes flags or sets the extension flag |
| swi | input | 1 | Software interrupt instruction strobe |
| swi_addr | input | 6 | Operand of the software interrupt |
| take | output | 1 | Interrupt accepted |
| vector | output | 16 | Entry address |
| ack | output | 1 | Acknowledge pulse to peripherals |
| push_f | output | 1 | Request to push the flag register |
| ien_clr | output | 1 | Request to clear the enable flag |

## Verification
Every result is due one clock after the edge that samples its stimulus. The guards add their own delays: a pair becomes valid on the edge that sees its second write, a `flag_wr` pulse affects only the next boundary, and an `nmi` edge can be served no earlier than the cycle after it is captured. The driver tags each expected output with the cycle number in which it is due. The monitor compares all five outputs only when that cycle comes, half a period after the edge, so a result that arrives a cycle late or early is caught.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

    localparam int VEC_W      = 16;
    localparam int SWI_W      = 6;
    localparam int PREFIX_W   = 8;
    localparam logic [PREFIX_W-1:0] SWI_PREFIX = 8'h01;
    localparam logic [VEC_W-1:0]    NMI_VEC    = 16'h0100;

    typedef enum logic [1:0] {
        SP_NONE  = 2'd0,
        SP_HALF  = 2'd1,
        SP_VALID = 2'd2
    } sp_state_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_SWI  = 2'd1,
        SRC_NMI  = 2'd2,
        SRC_IRQ  = 2'd3
    } src_e;

    typedef struct packed {
        logic             take;
        logic [VEC_W-1:0] vec;
        logic             ack;
        logic             push_f;
        logic             ien_clr;
    } entry_t;

    function automatic logic [VEC_W-1:0] swi_vector(input logic [SWI_W-1:0] addr);
        logic [VEC_W-1:0] v;
        v = '0;
        v[VEC_W-1 -: PREFIX_W] = SWI_PREFIX;
        v[SWI_W-1:0] = addr;
        return v;
    endfunction

endpackage

// File: rtl/irq_sp_pair.sv
module irq_sp_pair
    import irq_gate_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_a,
    input  logic wr_b,
    output logic pair_ok
);
    sp_state_e state_q, state_d;
    logic      half_b_q, half_b_d;   // in SP_HALF: 1 when the lone write was pointer b

    always_comb begin
        state_d  = state_q;
        half_b_d = half_b_q;
        if (wr_a && wr_b) begin
            state_d = SP_VALID;
        end else if (wr_a || wr_b) begin
            if (state_q == SP_HALF && (wr_b != half_b_q)) begin
                state_d = SP_VALID;
            end else begin
                state_d  = SP_HALF;
                half_b_d = wr_b;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SP_NONE;
            half_b_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            half_b_q <= half_b_d;
        end
    end

    assign pair_ok = (state_q == SP_VALID);

    p_single_write_breaks_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == SP_VALID && (wr_a ^ wr_b)) |=> !pair_ok);

    p_repeat_write_holds_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == SP_HALF && wr_a && !wr_b && !half_b_q) |=> (state_q == SP_HALF));

endmodule

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge (
    input  logic clk,
    input  logic rst,
    input  logic nmi,
    input  logic consume,
    output logic pending
);
    logic prev_q;
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= nmi;
            pend_q <= (pend_q && !consume) || (nmi && !prev_q);
        end
    end

    assign pending = pend_q;

    p_nmi_held_r6: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !consume) |=> pend_q);

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_gate_pkg::*;
(
    input  logic             swi,
    input  logic [SWI_W-1:0] swi_addr,
    input  logic             hw_ok,
    input  logic             nmi_pend,
    input  logic             irq,
    input  logic             ien,
    input  logic [VEC_W-1:0] irq_vec,
    output src_e             src,
    output entry_t           entry
);
    always_comb begin
        if (swi)                    src = SRC_SWI;
        else if (hw_ok && nmi_pend) src = SRC_NMI;
        else if (hw_ok && irq && ien) src = SRC_IRQ;
        else                        src = SRC_NONE;
    end

    always_comb begin
        entry = '0;
        unique case (src)
            SRC_SWI: begin
                entry.take   = 1'b1;
                entry.vec    = swi_vector(swi_addr);
                entry.push_f = 1'b1;
            end
            SRC_NMI: begin
                entry.take    = 1'b1;
                entry.vec     = NMI_VEC;
                entry.ack     = 1'b1;
                entry.push_f  = 1'b1;
                entry.ien_clr = 1'b1;
            end
            SRC_IRQ: begin
                entry.take    = 1'b1;
                entry.vec     = irq_vec;
                entry.ack     = 1'b1;
                entry.push_f  = 1'b1;
                entry.ien_clr = 1'b1;
            end
            default: entry = '0;
        endcase
    end

endmodule

// File: rtl/irq_gate.sv
module irq_gate
    import irq_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             boundary,
    input  logic             irq,
    input  logic [VEC_W-1:0] irq_vec,
    input  logic             nmi,
    input  logic             ien,
    input  logic             sp1_wr,
    input  logic             sp2_wr,
    input  logic             flag_wr,
    input  logic             swi,
    input  logic [SWI_W-1:0] swi_addr,
    output logic             take,
    output logic [VEC_W-1:0] vector,
    output logic             ack,
    output logic             push_f,
    output logic             ien_clr
);
    logic   pair_ok;
    logic   nmi_pend;
    logic   defer_q;
    logic   hw_ok;
    src_e   src;
    entry_t entry_d, entry_q;

    irq_sp_pair u_pair (
        .clk     (clk),
        .rst     (rst),
        .wr_a    (sp1_wr),
        .wr_b    (sp2_wr),
        .pair_ok (pair_ok)
    );

    irq_nmi_edge u_nmi (
        .clk     (clk),
        .rst     (rst),
        .nmi     (nmi),
        .consume (src == SRC_NMI),
        .pending (nmi_pend)
    );

    // deferral: armed by a flag write, spent by the next boundary
    always_ff @(posedge clk) begin
        if (rst) defer_q <= 1'b0;
        else     defer_q <= flag_wr || (defer_q && !boundary);
    end

    assign hw_ok = boundary && pair_ok && !defer_q;

    irq_arbiter u_arb (
        .swi      (swi),
        .swi_addr (swi_addr),
        .hw_ok    (hw_ok),
        .nmi_pend (nmi_pend),
        .irq      (irq),
        .ien      (ien),
        .irq_vec  (irq_vec),
        .src      (src),
        .entry    (entry_d)
    );

    always_ff @(posedge clk) begin
        if (rst) entry_q <= '0;
        else     entry_q <= entry_d;
    end

    assign take    = entry_q.take;
    assign vector  = entry_q.vec;
    assign ack     = entry_q.ack;
    assign push_f  = entry_q.push_f;
    assign ien_clr = entry_q.ien_clr;

    p_hw_needs_pair_r1: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(pair_ok));

    p_defer_blocks_r3: assert property (@(posedge clk) disable iff (rst)
        ack |-> !$past(defer_q));

    p_swi_prefix_r4: assert property (@(posedge clk) disable iff (rst)
        (take && !ack) |-> (vector[VEC_W-1 -: PREFIX_W] == SWI_PREFIX));

    p_hw_at_boundary_r9: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(boundary));

endmodule

// File: tb/irq_gate_tb.sv
module irq_gate_tb;
    import irq_gate_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic             rst = 1'b1, boundary = 1'b0, irq = 1'b0, nmi = 1'b0, ien = 1'b0;
    logic             sp1_wr = 1'b0, sp2_wr = 1'b0, flag_wr = 1'b0, swi = 1'b0;
    logic [SWI_W-1:0] swi_addr = '0;
    logic [VEC_W-1:0] irq_vec = 16'h1234;
    logic             take, ack, push_f, ien_clr;
    logic [VEC_W-1:0] vector;

    irq_gate u_dut (
        .clk(clk), .rst(rst), .boundary(boundary), .irq(irq), .irq_vec(irq_vec),
        .nmi(nmi), .ien(ien), .sp1_wr(sp1_wr), .sp2_wr(sp2_wr), .flag_wr(flag_wr),
        .swi(swi), .swi_addr(swi_addr), .take(take), .vector(vector), .ack(ack),
        .push_f(push_f), .ien_clr(ien_clr)
    );

    typedef struct {
        int     due;
        entry_t exp;
        string  tag;
    } item_t;

    item_t q[$];
    int cycle = 0;
    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always @(posedge clk) cycle <= cycle + 1;

    // monitor: compare each expected item in the cycle it is due
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due == cycle) begin
            item_t it;
            entry_t act;
            it = q.pop_front();
            act = '{take: take, vec: vector, ack: ack, push_f: push_f, ien_clr: ien_clr};
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual take=%b vec=%h ack=%b push=%b clr=%b expected take=%b vec=%h ack=%b push=%b clr=%b",
                    it.tag, act.take, act.vec, act.ack, act.push_f, act.ien_clr,
                    it.exp.take, it.exp.vec, it.exp.ack, it.exp.push_f, it.exp.ien_clr);
            end
        end
    end

    function automatic entry_t mk(bit t, logic [VEC_W-1:0] v, bit a, bit p, bit c);
        entry_t e;
        e.take = t; e.vec = v; e.ack = a; e.push_f = p; e.ien_clr = c;
        return e;
    endfunction

    task automatic drv(bit r, bit b, bit i, bit e, bit n, bit s1, bit s2, bit f,
                       bit sw, logic [SWI_W-1:0] ad, entry_t ex, string tag);
        item_t it;
        @(negedge clk);
        rst = r; boundary = b; irq = i; ien = e; nmi = n;
        sp1_wr = s1; sp2_wr = s2; flag_wr = f; swi = sw; swi_addr = ad;
        it.due = cycle + 1; it.exp = ex; it.tag = tag;
        q.push_back(it);
    endtask

    initial begin
        entry_t none;
        none = mk(0, 16'h0000, 0, 0, 0);
        drv(1,0,0,0,0,0,0,0,0,6'h00, none, "R1 reset");
        drv(1,0,0,0,0,0,0,0,0,6'h00, none, "R1 reset");
        drv(0,1,1,1,0,0,0,0,0,6'h00, none, "R1 no pair yet");
        drv(0,0,0,0,0,0,0,0,1,6'h05, mk(1,16'h0105,0,1,0), "R4 swi before pair");
        drv(0,0,0,0,1,0,0,0,0,6'h00, none, "R6 nmi pulse");
        drv(0,1,0,0,0,0,0,0,0,6'h00, none, "R1 nmi blocked");
        drv(0,0,0,0,0,1,0,0,0,6'h00, none, "R2 sp1 only");
        drv(0,1,1,1,0,0,0,0,0,6'h00, none, "R2 half blocked");
        drv(0,0,0,0,0,1,0,0,0,6'h00, none, "R2 sp1 again");
        drv(0,1,1,1,0,0,0,0,0,6'h00, none, "R2 repeat stays blocked");
        drv(0,0,0,0,0,0,1,0,0,6'h00, none, "R2 sp2 completes");
        drv(0,1,1,1,0,0,0,0,0,6'h00, mk(1,16'h0100,1,1,1), "R7 R6 nmi over irq");
        drv(0,1,1,0,0,0,0,0,0,6'h00, none, "R5 ien low");
        drv(0,0,1,1,0,0,0,0,0,6'h00, none, "R9 no boundary");
        irq_vec = 16'hBEEF;
        drv(0,1,1,1,0,0,0,0,0,6'h00, mk(1,16'hBEEF,1,1,1), "R5 maskable");
        drv(0,0,0,0,0,0,0,0,0,6'h00, none, "R8 single pulse");
        drv(0,1,1,1,0,0,0,0,1,6'h2A, mk(1,16'h012A,0,1,0), "R7 swi first");
        drv(0,0,0,0,0,0,0,1,0,6'h00, none, "R3 flag write");
        drv(0,1,1,1,0,0,0,0,0,6'h00, none, "R3 deferred");
        drv(0,0,0,0,0,0,0,0,0,6'h00, none, "R3 gap");
        drv(0,1,1,1,0,0,0,0,0,6'h00, mk(1,16'hBEEF,1,1,1), "R3 resumes");
        drv(0,0,0,0,0,0,0,1,0,6'h00, none, "R3 flag write");
        drv(0,1,1,0,0,0,0,0,1,6'h3F, mk(1,16'h013F,0,1,0), "R4 swi during defer");
        drv(0,0,0,0,1,0,1,0,0,6'h00, none, "R2 sp2 only with nmi");
        drv(0,1,0,0,0,0,0,0,0,6'h00, none, "R2 broken pair");
        drv(0,0,0,0,0,1,0,0,0,6'h00, none, "R2 sp1 restores");
        drv(0,1,0,0,0,0,0,0,0,6'h00, mk(1,16'h0100,1,1,1), "R2 R6 nmi after restore");
        drv(0,0,0,0,0,1,0,0,0,6'h00, none, "R2 sp1 only");
        drv(0,0,0,0,0,1,1,0,0,6'h00, none, "R2 both same cycle");
        drv(0,1,1,1,0,0,0,0,0,6'h00, mk(1,16'hBEEF,1,1,1), "R2 pair via both");
        drv(0,0,0,0,0,0,0,0,0,6'h00, none, "R8 idle");
        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL pending: actual %0d items left expected 0", q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule